// File: doc/BRIEF.md
# Sixteen-Bit Word Core with Load, Add, Branch and Trap

This block is a small multi-cycle processor core. It executes a five-instruction subset of a 16-bit, byte-addressed instruction set: register or immediate add, a PC-relative address computation, a word load from base plus offset, a conditional branch on the condition flags, and a trap. A trap saves a return address and jumps through a vector table held in memory. The core holds eight 16-bit general registers, a program counter and a one-hot set of negative/zero/positive flags. It talks to one word-wide memory port, which serves both instruction fetches and data reads.

Execution is paced by a `go` input. In its idle state the core waits, and one instruction starts on every cycle in which `go` is high there. A host can therefore hold `go` high to run freely, or pulse it to single-step and compare the architectural state at checkpoints. Debug outputs expose the whole register file, the PC, the flags and a count of retired instructions.

An opcode outside the subset, or a register-form add whose spare bits are not zero, sends the core into a halted state. It stays there until reset.

The sequencer has six states:
- IDLE waits for `go` and moves to FETCH.
- FETCH requests the word at the PC and moves to DECODE.
- DECODE takes the returned word. It finishes ADD, LEA and BR and goes back to IDLE. It moves to MEMRD for LDW and TRAP. It moves to HALT on an illegal word.
- MEMRD requests the data or vector word and moves to MEMWB.
- MEMWB finishes the load or the trap jump and returns to IDLE.
- HALT is terminal.

Top module: `wc_core`

## Requirements
- R1: After reset the PC is 0x3000, all eight registers are 0, the flags read Z (`dbg_nzp` = 3'b010, with bit 2 = N, bit 1 = Z, bit 0 = P), the retired count is 0, `halted` is low and `idle` is high.
- R2: ADD (opcode bits [15:12] = 0001) writes register [11:9]. The written value is register [8:6] plus, when bit 5 is 1, the sign-extended bits [4:0], or, when bit 5 is 0, register [2:0]. The flags are set from the result.
- R3: LEA (1110) writes register [11:9] with PC+2 plus twice the sign-extended bits [8:0], and sets the flags from that value.
- R4: LDW (0110) reads the word at register [8:6] plus twice the sign-extended bits [5:0] into register [11:9], with address bit 0 ignored, and sets the flags from the loaded word.
- R5: BR (0000) sets the PC to PC+2 plus twice the sign-extended bits [8:0] when the mask in bits [11:9] (bit 11 = N, bit 10 = Z, bit 9 = P) shares a set bit with the current flags. Otherwise it falls through to PC+2. A mask of 000 never branches and 111 always does; the flags are unchanged.
- R6: TRAP (1111) writes R7 = PC+2 and loads the PC from the memory word at twice the zero-extended bits [7:0]. The flags are unchanged.
- R7: The flags are always exactly one of N, Z, P, derived from the sign and zero-ness of the last value written by ADD, LEA or LDW.
- R8: Every instruction that does not branch or trap advances the PC by 2. Every completed instruction adds exactly 1 to the retired count.
- R9: A memory read is requested by `mem_rd` with the address on `mem_addr`, whose bit 0 is always 0. `mem_rdata` is taken on the cycle after the request.
- R10: While the core is idle and `go` is low, no fetch starts and the PC, registers, flags and count stay unchanged.
- R11: An opcode outside the subset, or an ADD with bit 5 = 0 and bits [4:3] not 00, raises `halted`. The core then stops, and `halted` stays high with the architectural state frozen until reset.
- R12: The countdown program (LEA, LDW of 10, a loop of ADD -1 / BRz / BR, then TRAP x25) reaches R1 = 0x000A, PC = 0x3004 and P after 2 instructions. After 32 instructions it reaches R0 = 0x300C, R1 = 0, R7 = 0x300C, Z and PC = 0x0000 (vector word at 0x004A is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Starts one instruction per cycle while the core is idle |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Byte address of the requested word, bit 0 zero |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| idle | output | 1 | Core waits for `go` |
| halted | output | 1 | Sticky illegal-instruction halt |
| dbg_pc | output | 16 | Current PC |
| dbg_nzp | output | 3 | Flags {N, Z, P} |
| dbg_retired | output | 32 | Retired-instruction count |
| dbg_regs | output | 128 | Register file, R0 in bits [15:0] up to R7 in bits [127:112] |

## Verification
Each instruction returns to IDLE and exposes its whole result on the debug outputs. A wrong operand select, a wrong offset scaling or a wrong flag therefore appears at the ports on the first idle cycle after the faulty instruction, which is at most five cycles after it was fetched. A wrong branch decision or trap target appears as a PC mismatch at that point. If the state itself drifts, the PC diverges from the spec model at once. A wrong sequencer transition shows up either as a missing return to `idle`, caught within a few cycles, or as a count that moves by other than one.

// File: rtl/wc_pkg.sv
package wc_pkg;
    localparam int WORD_W  = 16;
    localparam int REG_CNT = 8;
    localparam int RIDX_W  = $clog2(REG_CNT);
    localparam logic [WORD_W-1:0] ALIGN_MASK = ~WORD_W'(1);

    localparam logic [3:0] OP_BR   = 4'b0000;
    localparam logic [3:0] OP_ADD  = 4'b0001;
    localparam logic [3:0] OP_LDW  = 4'b0110;
    localparam logic [3:0] OP_LEA  = 4'b1110;
    localparam logic [3:0] OP_TRAP = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_MEMRD,
        ST_MEMWB,
        ST_HALT
    } state_e;

    // {N, Z, P} from a written value
    function automatic logic [2:0] nzp_of(input logic [WORD_W-1:0] v);
        logic zero;
        zero = (v == '0);
        return {v[WORD_W-1], zero, ~v[WORD_W-1] & ~zero};
    endfunction
endpackage

// File: rtl/wc_regfile.sv
module wc_regfile #(
    parameter int W = wc_pkg::WORD_W,
    parameter int N = wc_pkg::REG_CNT,
    localparam int AW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [W-1:0]   wdata,
    input  logic [AW-1:0]  raddr_a,
    input  logic [AW-1:0]  raddr_b,
    output logic [W-1:0]   rdata_a,
    output logic [W-1:0]   rdata_b,
    output logic [N*W-1:0] dump
);
    logic [W-1:0] regs_q [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[i] <= '0;
                else if (we && waddr == AW'(i))
                    regs_q[i] <= wdata;
            end
            assign dump[i*W +: W] = regs_q[i];
        end
    endgenerate

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/wc_exec.sv
module wc_exec #(
    parameter int W = wc_pkg::WORD_W
) (
    input  logic [15:0]  ir,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] add_res,
    output logic [W-1:0] seq_pc,
    output logic [W-1:0] rel_tgt,
    output logic [W-1:0] ldw_ea,
    output logic [W-1:0] trap_ea,
    output logic         add_ok
);
    logic [W-1:0] imm5_sx;
    logic [W-1:0] off6_x2;
    logic [W-1:0] off9_x2;

    always_comb begin
        imm5_sx = {{(W-5){ir[4]}}, ir[4:0]};
        off6_x2 = {{(W-7){ir[5]}}, ir[5:0], 1'b0};
        off9_x2 = {{(W-10){ir[8]}}, ir[8:0], 1'b0};
        seq_pc  = pc + W'(2);
        add_res = opa + (ir[5] ? imm5_sx : opb);
        rel_tgt = seq_pc + off9_x2;
        ldw_ea  = opa + off6_x2;
        trap_ea = {{(W-9){1'b0}}, ir[7:0], 1'b0};
        add_ok  = ir[5] | (ir[4:3] == 2'b00);
    end
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
    import wc_pkg::*;
#(
    parameter int               CNT_W    = 32,
    parameter logic [WORD_W-1:0] RESET_PC = 16'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [WORD_W-1:0] mem_addr,
    output logic [15:0]       ir_cur,
    input  logic [WORD_W-1:0] add_res,
    input  logic [WORD_W-1:0] seq_pc,
    input  logic [WORD_W-1:0] rel_tgt,
    input  logic [WORD_W-1:0] ldw_ea,
    input  logic [WORD_W-1:0] trap_ea,
    input  logic              add_ok,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic [WORD_W-1:0] pc,
    output logic [2:0]        nzp,
    output logic [CNT_W-1:0]  retired,
    output logic              idle,
    output logic              halted
);
    state_e            state_q, state_d;
    logic [WORD_W-1:0] pc_q, pc_d;
    logic [WORD_W-1:0] ea_q, ea_d;
    logic [15:0]       ir_q;
    logic [2:0]        nzp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              retire;
    logic              flag_upd;
    logic [3:0]        op;

    assign ir_cur = (state_q == ST_DECODE) ? mem_rdata : ir_q;
    assign op     = ir_cur[15:12];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= RESET_PC;
            ea_q  <= '0;
            ir_q  <= '0;
            nzp_q <= 3'b010;
            cnt_q <= '0;
        end else begin
            pc_q <= pc_d;
            ea_q <= ea_d;
            if (state_q == ST_DECODE) ir_q <= mem_rdata;
            if (flag_upd) nzp_q <= nzp_of(rf_wdata);
            if (retire)   cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Next state and next PC / effective address
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        ea_d    = ea_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_DECODE;
            ST_DECODE: begin
                state_d = ST_IDLE;
                case (op)
                    OP_ADD: begin
                        if (add_ok) pc_d = seq_pc;
                        else        state_d = ST_HALT;
                    end
                    OP_LEA: pc_d = seq_pc;
                    OP_BR:  pc_d = ((ir_cur[11:9] & nzp_q) != 3'b000) ? rel_tgt : seq_pc;
                    OP_LDW: begin
                        ea_d    = ldw_ea;
                        state_d = ST_MEMRD;
                    end
                    OP_TRAP: begin
                        ea_d    = trap_ea;
                        state_d = ST_MEMRD;
                    end
                    default: state_d = ST_HALT;
                endcase
            end
            ST_MEMRD: state_d = ST_MEMWB;
            ST_MEMWB: begin
                state_d = ST_IDLE;
                pc_d    = (op == OP_LDW) ? seq_pc : mem_rdata;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // Outputs: memory port, register write, flag update, retire
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = pc_q & ALIGN_MASK;
        rf_we    = 1'b0;
        rf_waddr = ir_cur[11:9];
        rf_wdata = add_res;
        flag_upd = 1'b0;
        retire   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: mem_rd = 1'b1;
            ST_DECODE: begin
                case (op)
                    OP_ADD: begin
                        rf_we    = add_ok;
                        flag_upd = add_ok;
                        retire   = add_ok;
                    end
                    OP_LEA: begin
                        rf_we    = 1'b1;
                        rf_wdata = rel_tgt;
                        flag_upd = 1'b1;
                        retire   = 1'b1;
                    end
                    OP_BR: retire = 1'b1;
                    OP_TRAP: begin
                        rf_we    = 1'b1;
                        rf_waddr = RIDX_W'(7);
                        rf_wdata = seq_pc;
                    end
                    default: ;
                endcase
            end
            ST_MEMRD: begin
                mem_rd   = 1'b1;
                mem_addr = ea_q & ALIGN_MASK;
            end
            ST_MEMWB: begin
                retire = 1'b1;
                if (op == OP_LDW) begin
                    rf_we    = 1'b1;
                    rf_wdata = mem_rdata;
                    flag_upd = 1'b1;
                end
            end
            ST_HALT: ;
            default: ;
        endcase
    end

    assign pc      = pc_q;
    assign nzp     = nzp_q;
    assign retired = cnt_q;
    assign idle    = (state_q == ST_IDLE);
    assign halted  = (state_q == ST_HALT);

    assert_mem_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[0] == 1'b0));

    assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(nzp_q) == 1);

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_q) && $stable(cnt_q) && $stable(nzp_q)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !go) |=> (idle && $stable(pc_q) && $stable(cnt_q) && !$past(mem_rd)));

    assert_retire_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/wc_core.sv
module wc_core
    import wc_pkg::*;
#(
    parameter int               CNT_W    = 32,
    parameter logic [WORD_W-1:0] RESET_PC = 16'h3000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    output logic                      mem_rd,
    output logic [WORD_W-1:0]         mem_addr,
    input  logic [WORD_W-1:0]         mem_rdata,
    output logic                      idle,
    output logic                      halted,
    output logic [WORD_W-1:0]         dbg_pc,
    output logic [2:0]                dbg_nzp,
    output logic [CNT_W-1:0]          dbg_retired,
    output logic [REG_CNT*WORD_W-1:0] dbg_regs
);
    logic [15:0]       ir_cur;
    logic [WORD_W-1:0] opa, opb;
    logic [WORD_W-1:0] add_res, seq_pc, rel_tgt, ldw_ea, trap_ea;
    logic              add_ok;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [WORD_W-1:0] rf_wdata;

    wc_regfile #(.W(WORD_W), .N(REG_CNT)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ir_cur[8:6]),
        .raddr_b (ir_cur[2:0]),
        .rdata_a (opa),
        .rdata_b (opb),
        .dump    (dbg_regs)
    );

    wc_exec #(.W(WORD_W)) u_exec (
        .ir      (ir_cur),
        .pc      (dbg_pc),
        .opa     (opa),
        .opb     (opb),
        .add_res (add_res),
        .seq_pc  (seq_pc),
        .rel_tgt (rel_tgt),
        .ldw_ea  (ldw_ea),
        .trap_ea (trap_ea),
        .add_ok  (add_ok)
    );

    wc_ctrl #(.CNT_W(CNT_W), .RESET_PC(RESET_PC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .ir_cur    (ir_cur),
        .add_res   (add_res),
        .seq_pc    (seq_pc),
        .rel_tgt   (rel_tgt),
        .ldw_ea    (ldw_ea),
        .trap_ea   (trap_ea),
        .add_ok    (add_ok),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .pc        (dbg_pc),
        .nzp       (dbg_nzp),
        .retired   (dbg_retired),
        .idle      (idle),
        .halted    (halted)
    );

    // R6: the link register holds the return address one cycle after the trap decode
    assert_trap_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_waddr == RIDX_W'(7) && ir_cur[15:12] == OP_TRAP)
        |=> (dbg_regs[7*WORD_W +: WORD_W] == $past(dbg_pc) + WORD_W'(2)));
endmodule

// File: tb/wc_core_tb_top.sv
module wc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        idle, halted;
    logic [15:0] dbg_pc;
    logic [2:0]  dbg_nzp;
    logic [31:0] dbg_retired;
    logic [127:0] dbg_regs;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [4096];

    logic [15:0] mreg [8];
    logic [15:0] mpc;
    logic [2:0]  mnzp;
    int          mcnt;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[12:1]];

    wc_core dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .idle(idle), .halted(halted), .dbg_pc(dbg_pc),
        .dbg_nzp(dbg_nzp), .dbg_retired(dbg_retired), .dbg_regs(dbg_regs)
    );

    function automatic int ix(input int a);
        return (a >> 1) & 12'hFFF;
    endfunction

    function automatic logic [15:0] rg(input int r);
        return dbg_regs[r*16 +: 16];
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // R9: word-aligned request address
    always @(negedge clk) if (rst_n && mem_rd) chk("R9", "mem_addr bit0", {31'b0, mem_addr[0]}, 32'd0);

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    task automatic do_reset();
        rst_n = 1'b0; go = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    task automatic do_step();
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (idle || halted) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] e_addi(input int d, input int s, input int imm);
        return 16'(32'h1000 | (d << 9) | (s << 6) | 32'h20 | (imm & 31));
    endfunction
    function automatic logic [15:0] e_addr(input int d, input int s1, input int s2);
        return 16'(32'h1000 | (d << 9) | (s1 << 6) | s2);
    endfunction
    function automatic logic [15:0] e_ldw(input int d, input int b, input int off);
        return 16'(32'h6000 | (d << 9) | (b << 6) | (off & 63));
    endfunction
    function automatic logic [15:0] e_lea(input int d, input int off);
        return 16'(32'hE000 | (d << 9) | (off & 511));
    endfunction
    function automatic logic [15:0] e_br(input int m, input int off);
        return 16'((m << 9) | (off & 511));
    endfunction

    function automatic logic [2:0] m_flags(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    // Spec model: one instruction; returns the requirement tag it exercises
    task automatic model_step(output string rq);
        logic [15:0] ir, v;
        int s9, s6, s5;
        ir = mem[ix(mpc)];
        s9 = ir[8] ? int'(ir[8:0]) - 512 : int'(ir[8:0]);
        s6 = ir[5] ? int'(ir[5:0]) - 64 : int'(ir[5:0]);
        s5 = ir[4] ? int'(ir[4:0]) - 32 : int'(ir[4:0]);
        rq = "R8";
        case (ir[15:12])
            4'b0001: begin
                rq = "R2";
                v = ir[5] ? 16'(int'(mreg[ir[8:6]]) + s5) : 16'(mreg[ir[8:6]] + mreg[ir[2:0]]);
                mreg[ir[11:9]] = v; mnzp = m_flags(v); mpc = mpc + 16'd2;
            end
            4'b1110: begin
                rq = "R3";
                v = 16'(int'(mpc) + 2 + 2 * s9);
                mreg[ir[11:9]] = v; mnzp = m_flags(v); mpc = mpc + 16'd2;
            end
            4'b0110: begin
                rq = "R4";
                v = mem[ix(int'(mreg[ir[8:6]]) + 2 * s6)];
                mreg[ir[11:9]] = v; mnzp = m_flags(v); mpc = mpc + 16'd2;
            end
            4'b0000: begin
                rq = "R5";
                if ((ir[11:9] & mnzp) != 3'b000) mpc = 16'(int'(mpc) + 2 + 2 * s9);
                else mpc = mpc + 16'd2;
            end
            4'b1111: begin
                rq = "R6";
                mreg[7] = mpc + 16'd2;
                mpc = mem[ix(2 * int'(ir[7:0]))];
            end
            default: ;
        endcase
        mcnt++;
    endtask

    task automatic compare_all(input string rq);
        chk(rq, "pc", {16'b0, dbg_pc}, {16'b0, mpc});
        chk("R7", "nzp", {29'b0, dbg_nzp}, {29'b0, mnzp});
        chk("R8", "retired", dbg_retired, mcnt);
        for (int r = 0; r < 8; r++) chk(rq, $sformatf("reg%0d", r), {16'b0, rg(r)}, {16'b0, mreg[r]});
    endtask

    initial begin
        int a;
        string rq;
        // ---------- R1 reset ----------
        clear_mem();
        do_reset();
        chk("R1", "pc", {16'b0, dbg_pc}, 32'h3000);
        chk("R1", "regs", {31'b0, dbg_regs == '0}, 32'd1);
        chk("R1", "nzp", {29'b0, dbg_nzp}, 32'b010);
        chk("R1", "retired", dbg_retired, 32'd0);
        chk("R1", "halted/idle", {30'b0, halted, idle}, 32'b01);

        // ---------- R12 countdown ----------
        mem[ix(16'h3000)] = 16'hE005; mem[ix(16'h3002)] = 16'h6200;
        mem[ix(16'h3004)] = 16'h127F; mem[ix(16'h3006)] = 16'h0401;
        mem[ix(16'h3008)] = 16'h0FFD; mem[ix(16'h300A)] = 16'hF025;
        mem[ix(16'h300C)] = 16'h000A; mem[ix(16'h004A)] = 16'h0000;
        // R10: no progress while go is low
        repeat (10) @(negedge clk);
        chk("R10", "pc held", {16'b0, dbg_pc}, 32'h3000);
        chk("R10", "retired held", dbg_retired, 32'd0);
        chk("R10", "idle held", {31'b0, idle}, 32'd1);
        repeat (2) do_step();
        chk("R12", "R0@2", {16'b0, rg(0)}, 32'h300C);
        chk("R12", "R1@2", {16'b0, rg(1)}, 32'h000A);
        chk("R12", "pc@2", {16'b0, dbg_pc}, 32'h3004);
        chk("R12", "nzp@2", {29'b0, dbg_nzp}, 32'b001);
        chk("R12", "count@2", dbg_retired, 32'd2);
        repeat (30) do_step();
        chk("R12", "R0@32", {16'b0, rg(0)}, 32'h300C);
        chk("R12", "R1@32", {16'b0, rg(1)}, 32'h0000);
        chk("R12", "R7@32", {16'b0, rg(7)}, 32'h300C);
        chk("R12", "nzp@32", {29'b0, dbg_nzp}, 32'b010);
        chk("R12", "pc@32", {16'b0, dbg_pc}, 32'h0000);
        chk("R12", "count@32", dbg_retired, 32'd32);

        // ---------- sweep program against spec model ----------
        clear_mem();
        a = 16'h3000;
        mem[ix(a)] = e_br(7, 4); a += 2;
        mem[ix(a)] = 16'h8000; a += 2;
        mem[ix(a)] = 16'h0000; a += 2;
        mem[ix(a)] = 16'h7FFF; a += 2;
        mem[ix(a)] = 16'h1234; a += 2;
        mem[ix(a)] = e_lea(3, -5); a += 2;      // R3 = 0x3002
        mem[ix(a)] = e_addi(4, 3, 1); a += 2;   // odd base
        mem[ix(a)] = e_ldw(1, 4, 1); a += 2;    // 0x3005 -> word at 0x3004
        for (int k = 0; k < 4; k++) begin
            mem[ix(a)] = e_ldw(1, 3, k); a += 2;
            for (int imm = 0; imm < 32; imm++) begin
                mem[ix(a)] = e_addi(2, 1, imm); a += 2;
                mem[ix(a)] = e_addr(5, 2, 1); a += 2;
            end
        end
        for (int f = 0; f < 3; f++)
            for (int m = 0; m < 8; m++) begin
                mem[ix(a)] = e_ldw(6, 3, f); a += 2;
                mem[ix(a)] = e_br(m, 1); a += 2;
                mem[ix(a)] = e_addi(7, 7, 1); a += 2;
            end
        mem[ix(a)] = 16'hF020;
        mem[ix(16'h0040)] = 16'h3A00;
        mem[ix(16'h3A00)] = 16'h2000;           // outside the subset
        do_reset();
        for (int r = 0; r < 8; r++) mreg[r] = 16'h0;
        mpc = 16'h3000; mnzp = 3'b010; mcnt = 0;
        for (int n = 0; n < 400; n++) begin
            if (mpc == 16'h3A00) break;
            model_step(rq);
            do_step();
            compare_all(rq);
        end
        chk("R6", "reached trap target", {16'b0, dbg_pc}, 32'h3A00);

        // ---------- R11 illegal opcode ----------
        do_step();
        chk("R11", "halted", {31'b0, halted}, 32'd1);
        repeat (5) @(negedge clk);
        chk("R11", "halted sticky", {31'b0, halted}, 32'd1);
        chk("R11", "pc frozen", {16'b0, dbg_pc}, 32'h3A00);
        chk("R11", "count frozen", dbg_retired, mcnt);

        // R11: register-form ADD with nonzero bits [4:3]
        clear_mem();
        mem[ix(16'h3000)] = 16'h1248;
        do_reset();
        do_step();
        chk("R11", "add spare bits halted", {31'b0, halted}, 32'd1);
        chk("R11", "R1 untouched", {16'b0, rg(1)}, 32'h0000);
        chk("R11", "nzp untouched", {29'b0, dbg_nzp}, 32'b010);
        chk("R11", "count untouched", dbg_retired, 32'd0);

        summary();
        $finish;
    end
endmodule